// File: doc/BRIEF.md
# Leapfrog Segmented DAC Code Decoder

This block turns a 16-bit converter code into the digital control words of a segmented converter. The converter is made of a string of 16 equal resistors (17 nodes, numbered 0 to 16), two tap selectors that each pick one node of the string, and a 12-bit interpolating DAC. The interpolating DAC spans the voltage between the two selected taps. The upper four code bits pick the segment, and the lower twelve set the position inside it.

Moving between segments does not place the taps at bottom and top each time. Instead the taps leapfrog. Only one tap moves when the code enters the next segment; it jumps to the far end of the new segment. The other tap stays on the node the two segments share. The roles of the taps therefore alternate from segment to segment. On segments where they are swapped, the fine code is complemented so that the analog output still rises with the code. A small two-state orientation machine tracks which role assignment is in force.

A new code is captured when the load strobe is sampled high. All outputs come from registers. The analog string, buffers and interpolator belong to other blocks.

Top module: `leap_decoder`

States and transitions of the orientation machine:
- `ORIENT_EVEN`: tap A is on the lower node and tap B on the upper node; the fine code passes through unchanged.
- `ORIENT_ODD`: tap A is on the upper node and tap B on the lower node; the fine code is complemented.
- Transition "enter odd": from `ORIENT_EVEN` to `ORIENT_ODD` when a load captures a code whose segment index is odd.
- Transition "enter even": from `ORIENT_ODD` to `ORIENT_EVEN` when a load captures a code whose segment index is even.
- Transition "stay": any other cycle. Reset forces `ORIENT_EVEN`.

## Requirements
- R1: The segment index s is code bits [15:12]. The two tap outputs are unsigned node indices from 0 to 16, where node s is the lower end of segment s and node s+1 is its upper end.
- R2: For even s, tap A equals s and tap B equals s+1.
- R3: For odd s, tap A equals s+1 and tap B equals s.
- R4: For even s, the fine output equals code bits [11:0].
- R5: For odd s, the fine output equals the bitwise complement of code bits [11:0].
- R6: A code presented with load high is reflected on all outputs right after the rising edge that samples it. While load is low, all outputs hold their values whatever the code input does.
- R7: Synchronous reset, active high, sets tap A = 0, tap B = 1 and fine = 0. Reset takes priority over a simultaneous load.
- R8: After reset, the two taps always differ by exactly one node.
- R9: When a load moves the code from segment s to segment s+1, exactly one tap changes and the other stays on node s+1.
- R10: The ideal level tapA*4096 + fine*(tapB - tapA) never decreases when the code steps up by one across the full 0 to 65535 range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Captures code_i at the rising edge |
| code_i | input | 16 | Converter code |
| tap_a_o | output | 5 | Node index for the first tap selector |
| tap_b_o | output | 5 | Node index for the second tap selector |
| fine_o | output | 12 | Code for the interpolating DAC |

## Verification
The bench loads every code in ascending order and rebuilds the ideal level from the outputs. A missing complement on odd segments would make the level fall inside those segments. Swapped tap roles would produce a drop of a whole segment at each boundary. At every segment crossing the bench counts the taps that moved: a design that resets both taps to bottom and top would move two. Directed cases cover the code extremes 0x0000, 0x0FFF, 0x1000 and 0xFFFF, where an index that overflowed past node 16 would show. They also cover reset arriving together with a load, and a changing code with the load low, which a design that ignores the strobe would pass straight through.

// File: rtl/leap_pkg.sv
package leap_pkg;

    localparam int DEF_CODE_W = 16;
    localparam int DEF_SEG_W  = 4;

    typedef enum logic {
        ORIENT_EVEN = 1'b0,
        ORIENT_ODD  = 1'b1
    } orient_e;

endpackage

// File: rtl/leap_orient_fsm.sv
module leap_orient_fsm
    import leap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  logic    seg_odd_i,
    output orient_e orient_o,
    output logic    swap_o
);

    orient_e state_q;
    orient_e state_d;

    // next-state logic: enter odd / enter even / stay
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ORIENT_EVEN: begin
                if (load_i && seg_odd_i) begin
                    state_d = ORIENT_ODD;
                end
            end
            ORIENT_ODD: begin
                if (load_i && !seg_odd_i) begin
                    state_d = ORIENT_EVEN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ORIENT_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        orient_o = state_q;
        unique case (state_q)
            ORIENT_EVEN: swap_o = 1'b0;
            ORIENT_ODD:  swap_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/leap_tap_sel.sv
module leap_tap_sel
    import leap_pkg::*;
#(
    parameter int SEG_W  = DEF_SEG_W,
    localparam int NODE_W = SEG_W + 1
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  orient_e           orient_i,
    output logic [NODE_W-1:0] tap_a_o,
    output logic [NODE_W-1:0] tap_b_o
);

    logic [NODE_W-1:0] node_lo;
    logic [NODE_W-1:0] node_hi;

    always_comb begin
        node_lo = {1'b0, seg_i};
        node_hi = node_lo + NODE_W'(1);
        unique case (orient_i)
            ORIENT_EVEN: begin
                tap_a_o = node_lo;
                tap_b_o = node_hi;
            end
            ORIENT_ODD: begin
                tap_a_o = node_hi;
                tap_b_o = node_lo;
            end
        endcase
    end

endmodule

// File: rtl/leap_fine_map.sv
module leap_fine_map #(
    parameter int FINE_W = 12
) (
    input  logic [FINE_W-1:0] fine_raw_i,
    input  logic              swap_i,
    output logic [FINE_W-1:0] fine_o
);

    for (genvar gi = 0; gi < FINE_W; gi++) begin : g_bit
        assign fine_o[gi] = fine_raw_i[gi] ^ swap_i;
    end

endmodule

// File: rtl/leap_decoder.sv
module leap_decoder
    import leap_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int SEG_W  = DEF_SEG_W,
    localparam int FINE_W = CODE_W - SEG_W,
    localparam int NODE_W = SEG_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [NODE_W-1:0] tap_a_o,
    output logic [NODE_W-1:0] tap_b_o,
    output logic [FINE_W-1:0] fine_o
);

    logic [CODE_W-1:0] code_q;
    orient_e           orient;
    logic              swap;

    // captured code
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (load_i) begin
            code_q <= code_i;
        end
    end

    leap_orient_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .seg_odd_i(code_i[FINE_W]),
        .orient_o (orient),
        .swap_o   (swap)
    );

    leap_tap_sel #(.SEG_W(SEG_W)) u_taps (
        .seg_i   (code_q[CODE_W-1 -: SEG_W]),
        .orient_i(orient),
        .tap_a_o (tap_a_o),
        .tap_b_o (tap_b_o)
    );

    leap_fine_map #(.FINE_W(FINE_W)) u_fine (
        .fine_raw_i(code_q[FINE_W-1:0]),
        .swap_i    (swap),
        .fine_o    (fine_o)
    );

endmodule

// File: rtl/leap_decoder_checker.sv
module leap_decoder_checker #(
    parameter int CODE_W = 16,
    parameter int SEG_W  = 4,
    localparam int FINE_W = CODE_W - SEG_W,
    localparam int NODE_W = SEG_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [CODE_W-1:0] code_i,
    input logic [NODE_W-1:0] tap_a_o,
    input logic [NODE_W-1:0] tap_b_o,
    input logic [FINE_W-1:0] fine_o
);

    logic [NODE_W-1:0] seg_now;
    logic [NODE_W-1:0] seg_in;
    assign seg_now = (tap_a_o < tap_b_o) ? tap_a_o : tap_b_o;
    assign seg_in  = {1'b0, code_i[CODE_W-1 -: SEG_W]};

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (tap_a_o == '0 && tap_b_o == NODE_W'(1) && fine_o == '0));

    assert_adjacent_R8: assert property (@(posedge clk) disable iff (rst)
        ((tap_a_o > tap_b_o) ? (tap_a_o - tap_b_o) : (tap_b_o - tap_a_o)) == NODE_W'(1));

    assert_range_R1: assert property (@(posedge clk) disable iff (rst)
        (tap_a_o <= NODE_W'(1 << SEG_W)) && (tap_b_o <= NODE_W'(1 << SEG_W)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(tap_a_o) && $stable(tap_b_o) && $stable(fine_o)));

    assert_even_taps_R2: assert property (@(posedge clk) disable iff (rst)
        (load_i && !code_i[FINE_W]) |=>
            (tap_a_o == $past(seg_in) && tap_b_o == $past(seg_in) + NODE_W'(1)));

    assert_odd_taps_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && code_i[FINE_W]) |=>
            (tap_b_o == $past(seg_in) && tap_a_o == $past(seg_in) + NODE_W'(1)));

    assert_even_fine_R4: assert property (@(posedge clk) disable iff (rst)
        (load_i && !code_i[FINE_W]) |=> (fine_o == $past(code_i[FINE_W-1:0])));

    assert_odd_fine_R5: assert property (@(posedge clk) disable iff (rst)
        (load_i && code_i[FINE_W]) |=> (fine_o == ~$past(code_i[FINE_W-1:0])));

    assert_one_tap_moves_R9: assert property (@(posedge clk) disable iff (rst)
        (load_i && seg_in == seg_now + NODE_W'(1)) |=>
            ($countones({tap_a_o != $past(tap_a_o), tap_b_o != $past(tap_b_o)}) == 1));

endmodule

bind leap_decoder leap_decoder_checker #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .code_i (code_i),
    .tap_a_o(tap_a_o),
    .tap_b_o(tap_b_o),
    .fine_o (fine_o)
);

// File: tb/leap_decoder_bench.sv
module leap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [15:0] code_i = '0;
    logic [4:0]  tap_a_o;
    logic [4:0]  tap_b_o;
    logic [11:0] fine_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5ns clk = ~clk;

    leap_decoder u_leap_decoder (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .code_i (code_i),
        .tap_a_o(tap_a_o),
        .tap_b_o(tap_b_o),
        .fine_o (fine_o)
    );

    function automatic logic [4:0] exp_a(input logic [15:0] c);
        int s = int'(c[15:12]);
        return (s % 2 == 0) ? 5'(s) : 5'(s + 1);
    endfunction

    function automatic logic [4:0] exp_b(input logic [15:0] c);
        int s = int'(c[15:12]);
        return (s % 2 == 0) ? 5'(s + 1) : 5'(s);
    endfunction

    function automatic logic [11:0] exp_f(input logic [15:0] c);
        return c[12] ? ~c[11:0] : c[11:0];
    endfunction

    function automatic longint level(input logic [4:0] a, input logic [4:0] b,
                                     input logic [11:0] f);
        return longint'(a) * 4096 + longint'(f) * (longint'(b) - longint'(a));
    endfunction

    task automatic check(input string req, input logic [15:0] c);
        n_checks++;
        if (tap_a_o !== exp_a(c) || tap_b_o !== exp_b(c) || fine_o !== exp_f(c)) begin
            n_fail++;
            $display("FAIL %s code=%h actual a=%0d b=%0d f=%h expected a=%0d b=%0d f=%h",
                     req, c, tap_a_o, tap_b_o, fine_o, exp_a(c), exp_b(c), exp_f(c));
        end
    endtask

    task automatic drive(input logic ld, input logic [15:0] c);
        @(negedge clk);
        load_i = ld;
        code_i = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1500us;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected done");
            finish_run();
        end
    end

    initial begin
        logic [15:0] held;
        logic [4:0]  pa, pb;
        longint      plev;
        int          moved;
        void'($urandom(32'd20240611));

        // R7: reset state
        repeat (3) @(negedge clk);
        check("R7 reset", 16'h0000);
        rst = 1'b0;

        // directed corners R1 R2 R3 R4 R5 R6
        drive(1'b1, 16'h0FFF); check("R2 R4 top of segment 0", 16'h0FFF);
        drive(1'b1, 16'h1000); check("R3 R5 start of segment 1", 16'h1000);
        drive(1'b1, 16'hFFFF); check("R1 R3 R5 top code", 16'hFFFF);
        drive(1'b1, 16'hE123); check("R2 R4 segment 14", 16'hE123);
        held = 16'hE123;
        drive(1'b0, 16'h3ABC); check("R6 hold with load low", held);
        drive(1'b0, 16'h0000); check("R6 hold with load low", held);

        // R7: reset has priority over load
        @(negedge clk);
        rst = 1'b1; load_i = 1'b1; code_i = 16'hFFFF;
        @(negedge clk);
        rst = 1'b0; load_i = 1'b0;
        check("R7 reset beats load", 16'h0000);

        // constrained random mix of loads and holds
        held = 16'h0000;
        for (int i = 0; i < 2000; i++) begin
            logic        ld = ($urandom % 4) != 0;
            logic [15:0] c  = 16'($urandom);
            drive(ld, c);
            if (ld) held = c;
            check(ld ? "R2 R3 R4 R5 random load" : "R6 random hold", held);
        end

        // full ascending sweep: R8 R9 R10
        drive(1'b1, 16'h0000);
        pa = tap_a_o; pb = tap_b_o; plev = level(tap_a_o, tap_b_o, fine_o);
        @(negedge clk);
        for (int k = 1; k < 65536; k++) begin
            load_i = 1'b1;
            code_i = 16'(k);
            @(negedge clk);
            check("R1 sweep", 16'(k));
            n_checks++;
            if (!((tap_a_o - tap_b_o == 5'd1) || (tap_b_o - tap_a_o == 5'd1))) begin
                n_fail++;
                $display("FAIL R8 code=%h actual a=%0d b=%0d expected adjacent", k, tap_a_o, tap_b_o);
            end
            n_checks++;
            if (level(tap_a_o, tap_b_o, fine_o) < plev) begin
                n_fail++;
                $display("FAIL R10 code=%h actual level=%0d expected >= %0d",
                         k, level(tap_a_o, tap_b_o, fine_o), plev);
            end
            if (k[11:0] == 12'h000) begin
                moved = int'(tap_a_o != pa) + int'(tap_b_o != pb);
                n_checks++;
                if (moved != 1) begin
                    n_fail++;
                    $display("FAIL R9 code=%h actual moved=%0d expected 1", k, moved);
                end
            end
            pa = tap_a_o; pb = tap_b_o; plev = level(tap_a_o, tap_b_o, fine_o);
        end
        load_i = 1'b0;

        done = 1'b1;
        finish_run();
    end

endmodule